// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns four serial audio data pins into sixteen parallel 24-bit channel words. It never drives a clock. A bit clock and a frame clock come from an external master and are shared by all four data pins. These three signals are asynchronous to the core clock. The block brings them into the core clock domain, finds the rising edges of the bit clock and samples the data there.

A 3-bit format code selects one of these modes:

- three two-channel framings: I2S, left-justified and right-justified;
- dual-wire 8-channel TDM;
- single-wire 16-channel TDM.

A 2-bit code selects the word length. Each received word is placed in its channel slot of the output bus, sign-extended to 24 bits. A one-cycle strobe marks the moment at which a whole frame is complete.

Top module: `srx_rx`

## Requirements
- R1: Data pins and the frame clock are sampled on rising edges of the bit clock, after they pass through the same synchronizer depth as the bit clock. The frame strobe only follows a detected bit-clock rise.
- R2: Format codes are: 0 I2S, 1 left-justified, 2 right-justified, 3 dual-wire TDM, 4 single-wire TDM. Codes 5 to 7 capture nothing, raise no strobe and leave every channel word unchanged.
- R3: In I2S, frame clock low is the left half. The MSB arrives on the second bit-clock rise after a frame clock transition. Pin p feeds channel 2p (left) and channel 2p+1 (right).
- R4: In left-justified mode, frame clock high is the left half. The MSB arrives on the first bit-clock rise after a transition. The pin-to-channel mapping is the same as in R3.
- R5: In right-justified mode, frame clock high is the left half. The LSB is the last bit before the next transition. The word is captured at that transition.
- R6: Word-length code 0 selects 16 bits, code 1 selects 20 bits, and codes 2 and 3 select 24 bits. Bits past the word are ignored. Each word is sign-extended to 24 bits. Channel n occupies bits 24n+23 down to 24n of the output bus.
- R7: In TDM, the bit-clock rise that first samples the frame clock high is bit 0 of slot 0. Each slot is 32 bits long, with the MSB at slot bit 0.
- R8: In dual-wire TDM, channels 0 to 7 come from slots 0 to 7 of pin 3, and channels 8 to 15 come from slots 0 to 7 of pin 2. Pins 0 and 1 are ignored.
- R9: In single-wire TDM, channels 0 to 15 come from slots 0 to 15 of pin 2. The other pins are ignored.
- R10: The frame strobe is high for exactly one core cycle per frame. In two-channel modes it rises with the right-channel word. In TDM it rises with the word of the last slot.
- R11: Nothing is captured before the first frame-clock transition (TDM: the first frame sync) after reset. Two-channel modes leave channels 8 to 15 untouched.
- R12: Reset clears every channel word and the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External frame clock / TDM frame sync |
| sdin | input | 4 | Serial data pins |
| fmt | input | 3 | Format code |
| wlen | input | 2 | Word-length code |
| ch_data | output | 384 | Sixteen 24-bit channel words |
| frame_valid | output | 1 | One-cycle end-of-frame strobe |

## Verification
Two events can fall on the same bit-clock rise, and the bench provokes both.

- In dual-wire TDM, channel 7 from pin 3, channel 15 from pin 2 and the frame strobe all land on the same rise. The bench fills both pins with unrelated random words and checks all sixteen words in the cycle the strobe is seen.
- In right-justified mode, the capture of the previous half's word coincides with the first bit of the new half being shifted in. The bench fills the bits ahead of each word with random padding. A word corrupted by the incoming bit shows up as a mismatch.

// File: rtl/srx_pkg.sv
package srx_pkg;

   localparam int SAMPLE_W = 24;

   localparam logic [2:0] FMT_I2S    = 3'd0;
   localparam logic [2:0] FMT_LJ     = 3'd1;
   localparam logic [2:0] FMT_RJ     = 3'd2;
   localparam logic [2:0] FMT_TDM_X2 = 3'd3;
   localparam logic [2:0] FMT_TDM_X1 = 3'd4;

   // number of significant bits selected by the word-length code
   function automatic logic [5:0] wlen_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 6'd16;
         2'd1:    return 6'd20;
         default: return 6'd24;
      endcase
   endfunction

   // sign-extend the low bits of a shift window to the full sample width
   function automatic logic [SAMPLE_W-1:0] sext_word(input logic [SAMPLE_W-1:0] raw,
                                                     input logic [1:0] code);
      case (code)
         2'd0:    return {{8{raw[15]}}, raw[15:0]};
         2'd1:    return {{4{raw[19]}}, raw[19:0]};
         default: return raw;
      endcase
   endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/srx_track.sv
module srx_track #(
   parameter int POS_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bclk_s,
   input  logic             lr_s,
   input  logic             tdm,
   output logic             rise,
   output logic             boundary,
   output logic             lr_now,
   output logic             lr_old,
   output logic             locked_prev,
   output logic             locked_now,
   output logic [POS_W-1:0] pos
);
   localparam logic [POS_W-1:0] POS_MAX = '1;

   logic             bclk_d;
   logic             lr_q;
   logic             seen_q;
   logic             locked_q;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] pos_nx;

   always_comb begin
      rise     = bclk_s & ~bclk_d;
      // TDM counts from the sync rise only; stereo restarts on both edges
      boundary = rise & seen_q & (tdm ? (lr_s & ~lr_q) : (lr_s ^ lr_q));
      if (boundary)              pos_nx = '0;
      else if (pos_q == POS_MAX) pos_nx = pos_q;
      else                       pos_nx = pos_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bclk_d   <= 1'b0;
         lr_q     <= 1'b0;
         seen_q   <= 1'b0;
         locked_q <= 1'b0;
         pos_q    <= POS_MAX;
      end else begin
         bclk_d <= bclk_s;
         if (rise) begin
            seen_q <= 1'b1;
            lr_q   <= lr_s;
            pos_q  <= pos_nx;
            if (boundary) locked_q <= 1'b1;
         end
      end
   end

   assign lr_now      = lr_s;
   assign lr_old      = lr_q;
   assign locked_prev = locked_q;
   assign locked_now  = locked_q | boundary;
   assign pos         = pos_nx;
endmodule

// File: rtl/srx_lane.sv
module srx_lane #(
   parameter int SW = 24
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          shift,
   input  logic          din,
   output logic [SW-1:0] sh_q,
   output logic [SW-1:0] sh_nx
);
   assign sh_nx = {sh_q[SW-2:0], din};

   always_ff @(posedge clk) begin
      if (rst)        sh_q <= '0;
      else if (shift) sh_q <= sh_nx;
   end
endmodule

// File: rtl/srx_capture.sv
module srx_capture
   import srx_pkg::*;
#(
   parameter int NUM_PINS = 4,
   parameter int NUM_CH   = 16,
   parameter int SLOT_W   = 32,
   parameter int POS_W    = 10,
   parameter int PIN_LO   = 3,
   parameter int PIN_HI   = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                rise,
   input  logic                boundary,
   input  logic                lr_now,
   input  logic                lr_old,
   input  logic                locked_prev,
   input  logic                locked_now,
   input  logic [2:0]          fmt,
   input  logic [1:0]          wlen,
   input  logic [POS_W-1:0]    pos,
   input  logic [SAMPLE_W-1:0] lane_q  [NUM_PINS],
   input  logic [SAMPLE_W-1:0] lane_nx [NUM_PINS],
   output logic [SAMPLE_W-1:0] ch_q    [NUM_CH],
   output logic                frame_valid
);
   localparam int SLOT_LOG2 = $clog2(SLOT_W);
   localparam int SLOT_IW   = POS_W - SLOT_LOG2;
   localparam int HALF      = NUM_CH / 2;
   localparam int STEREO_CH = 2 * NUM_PINS;

   logic                 is_i2s, is_lj, is_rj, is_dual, is_single;
   logic [POS_W-1:0]     wbits;
   logic [SLOT_IW-1:0]   slot;
   logic [SLOT_LOG2-1:0] sbit;
   logic                 st_hit, st_left, tdm_hit, tdm_last, valid_nx;

   always_comb begin
      is_i2s    = (fmt == FMT_I2S);
      is_lj     = (fmt == FMT_LJ);
      is_rj     = (fmt == FMT_RJ);
      is_dual   = (fmt == FMT_TDM_X2);
      is_single = (fmt == FMT_TDM_X1);
      wbits     = POS_W'(wlen_bits(wlen));
      slot      = pos[POS_W-1:SLOT_LOG2];
      sbit      = pos[SLOT_LOG2-1:0];

      // stereo: LJ at the LSB, I2S one bit later, RJ at the next transition
      st_hit = (is_lj  & rise & locked_now & (pos == wbits - 1'b1))
             | (is_i2s & rise & locked_now & (pos == wbits))
             | (is_rj  & boundary & locked_prev);
      if (is_i2s)     st_left = ~lr_now;
      else if (is_lj) st_left = lr_now;
      else            st_left = lr_old;

      tdm_hit = rise & locked_now
              & (sbit == SLOT_LOG2'(wbits - 1'b1))
              & ((is_dual & (slot < SLOT_IW'(HALF))) | (is_single & (slot < SLOT_IW'(NUM_CH))));
      tdm_last = is_dual ? (slot == SLOT_IW'(HALF - 1)) : (slot == SLOT_IW'(NUM_CH - 1));

      valid_nx = (st_hit & ~st_left) | (tdm_hit & tdm_last);
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic                st_we, tdm_we;
      logic [SAMPLE_W-1:0] st_src, tdm_src, word_q;

      if (c < STEREO_CH) begin : g_st
         localparam int  P    = c / 2;
         localparam bit  LEFT = (c % 2 == 0);
         assign st_we  = st_hit & (st_left == LEFT);
         assign st_src = is_rj ? lane_q[P] : lane_nx[P];
      end else begin : g_nost
         assign st_we  = 1'b0;
         assign st_src = '0;
      end

      if (c < HALF) begin : g_lo
         assign tdm_we  = tdm_hit & (slot == SLOT_IW'(c));
         assign tdm_src = is_dual ? lane_nx[PIN_LO] : lane_nx[PIN_HI];
      end else begin : g_hi
         assign tdm_we  = tdm_hit & ((is_dual & (slot == SLOT_IW'(c - HALF)))
                                   | (is_single & (slot == SLOT_IW'(c))));
         assign tdm_src = lane_nx[PIN_HI];
      end

      always_ff @(posedge clk) begin
         if (rst)         word_q <= '0;
         else if (st_we)  word_q <= sext_word(st_src, wlen);
         else if (tdm_we) word_q <= sext_word(tdm_src, wlen);
      end

      assign ch_q[c] = word_q;
   end

   always_ff @(posedge clk) begin
      if (rst) frame_valid <= 1'b0;
      else     frame_valid <= valid_nx;
   end
endmodule

// File: rtl/srx_rx.sv
module srx_rx
   import srx_pkg::*;
#(
   parameter int NUM_PINS    = 4,
   parameter int NUM_CH      = 16,
   parameter int SLOT_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int PIN_LO      = 3,
   parameter int PIN_HI      = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       bclk,
   input  logic                       lrclk,
   input  logic [NUM_PINS-1:0]        sdin,
   input  logic [2:0]                 fmt,
   input  logic [1:0]                 wlen,
   output logic [NUM_CH*SAMPLE_W-1:0] ch_data,
   output logic                       frame_valid
);
   localparam int POS_W = $clog2(NUM_CH * SLOT_W) + 1;
   localparam int BUS_W = NUM_PINS + 2;

   if (NUM_CH % 2 != 0 || NUM_CH < 2 * NUM_PINS) begin : g_bad_ch
      $error("srx_rx: NUM_CH must be even and cover two channels per pin");
   end
   if (PIN_LO >= NUM_PINS || PIN_HI >= NUM_PINS || PIN_LO == PIN_HI) begin : g_bad_pin
      $error("srx_rx: TDM pin selection out of range");
   end
   if (SLOT_W < SAMPLE_W || (1 << $clog2(SLOT_W)) != SLOT_W) begin : g_bad_slot
      $error("srx_rx: SLOT_W must be a power of two no smaller than the sample");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("srx_rx: at least two synchronizer stages required");
   end

   logic [BUS_W-1:0]    raw_bus, sync_bus;
   logic                bclk_s, lr_s;
   logic [NUM_PINS-1:0] sd_s;
   logic                is_tdm;
   logic                rise, boundary, lr_now, lr_old, locked_prev, locked_now;
   logic [POS_W-1:0]    pos;
   logic [SAMPLE_W-1:0] lane_q  [NUM_PINS];
   logic [SAMPLE_W-1:0] lane_nx [NUM_PINS];
   logic [SAMPLE_W-1:0] ch_q    [NUM_CH];

   assign raw_bus = {sdin, lrclk, bclk};

   srx_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_bus),
      .q   (sync_bus)
   );

   assign bclk_s = sync_bus[0];
   assign lr_s   = sync_bus[1];
   assign sd_s   = sync_bus[BUS_W-1:2];
   assign is_tdm = (fmt == FMT_TDM_X2) || (fmt == FMT_TDM_X1);

   srx_track #(.POS_W(POS_W)) u_track (
      .clk         (clk),
      .rst         (rst),
      .bclk_s      (bclk_s),
      .lr_s        (lr_s),
      .tdm         (is_tdm),
      .rise        (rise),
      .boundary    (boundary),
      .lr_now      (lr_now),
      .lr_old      (lr_old),
      .locked_prev (locked_prev),
      .locked_now  (locked_now),
      .pos         (pos)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
      srx_lane #(.SW(SAMPLE_W)) u_lane (
         .clk   (clk),
         .rst   (rst),
         .shift (rise),
         .din   (sd_s[p]),
         .sh_q  (lane_q[p]),
         .sh_nx (lane_nx[p])
      );
   end

   srx_capture #(
      .NUM_PINS (NUM_PINS),
      .NUM_CH   (NUM_CH),
      .SLOT_W   (SLOT_W),
      .POS_W    (POS_W),
      .PIN_LO   (PIN_LO),
      .PIN_HI   (PIN_HI)
   ) u_capture (
      .clk         (clk),
      .rst         (rst),
      .rise        (rise),
      .boundary    (boundary),
      .lr_now      (lr_now),
      .lr_old      (lr_old),
      .locked_prev (locked_prev),
      .locked_now  (locked_now),
      .fmt         (fmt),
      .wlen        (wlen),
      .pos         (pos),
      .lane_q      (lane_q),
      .lane_nx     (lane_nx),
      .ch_q        (ch_q),
      .frame_valid (frame_valid)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_out
      assign ch_data[c*SAMPLE_W +: SAMPLE_W] = ch_q[c];
   end
endmodule

// File: rtl/srx_rx_chk.sv
module srx_rx_chk #(
   parameter int NUM_PINS    = 4,
   parameter int NUM_CH      = 16,
   parameter int SYNC_STAGES = 2
) (
   input logic               clk,
   input logic               rst,
   input logic               bclk,
   input logic [2:0]         fmt,
   input logic [NUM_CH*24-1:0] ch_data,
   input logic               frame_valid
);
   localparam int LO_TOP = 2 * NUM_PINS * 24;

   // R10: the strobe never lasts two cycles
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
      frame_valid |=> !frame_valid);

   // R2: reserved codes never produce a strobe
   a_r2_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
      frame_valid |-> ($past(fmt) <= 3'd4));

   // R11: two-channel modes leave the upper channel words untouched
   a_r11_upper_hold: assert property (@(posedge clk) disable iff (rst)
      ($past(fmt) <= 3'd2) |-> $stable(ch_data[NUM_CH*24-1:LO_TOP]));

   // R1: a strobe follows a low-to-high step of the bit clock pin
   a_r1_strobe_after_rise: assert property (@(posedge clk) disable iff (rst)
      frame_valid |-> ($past(bclk, SYNC_STAGES + 1) && !$past(bclk, SYNC_STAGES + 2)));
endmodule

bind srx_rx srx_rx_chk #(
   .NUM_PINS    (NUM_PINS),
   .NUM_CH      (NUM_CH),
   .SYNC_STAGES (SYNC_STAGES)
) u_srx_rx_chk (
   .clk         (clk),
   .rst         (rst),
   .bclk        (bclk),
   .fmt         (fmt),
   .ch_data     (ch_data),
   .frame_valid (frame_valid)
);

// File: tb/test_srx_rx.sv
module test_srx_rx;
   localparam int NCH = 16;
   localparam int SW  = 24;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             bclk = 1'b0;
   logic             lrclk = 1'b0;
   logic [3:0]       sdin = 4'd0;
   logic [2:0]       fmt = 3'd0;
   logic [1:0]       wlen = 2'd0;
   logic [NCH*SW-1:0] ch_data;
   logic             frame_valid;

   always #10 clk = ~clk;

   srx_rx i_srx_rx (
      .clk         (clk),
      .rst         (rst),
      .bclk        (bclk),
      .lrclk       (lrclk),
      .sdin        (sdin),
      .fmt         (fmt),
      .wlen        (wlen),
      .ch_data     (ch_data),
      .frame_valid (frame_valid)
   );

   int errors = 0;
   int checks = 0;
   bit done   = 0;
   bit prev_v = 0;
   logic [NCH*SW-1:0] snaps[$];
   logic [SW-1:0]     expw[$];

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor, compared on every clock away from the active edge
   always @(negedge clk) begin
      if (!rst && frame_valid) begin
         snaps.push_back(ch_data);
         chk(!prev_v, "R10 strobe width", 1, 0);
      end
      prev_v = frame_valid;
   end

   function automatic int nbits(input logic [1:0] code);
      return (code == 2'd0) ? 16 : (code == 2'd1) ? 20 : 24;
   endfunction

   function automatic logic [SW-1:0] sx(input int unsigned v, input int w);
      int unsigned m = (w == 32) ? 32'hffff_ffff : ((32'd1 << w) - 1);
      int unsigned r = v & m;
      if (((r >> (w - 1)) & 1) != 0) r = r | ~m;
      return r[SW-1:0];
   endfunction

   task automatic bit_out(input logic l, input logic [3:0] d);
      @(negedge clk);
      bclk  = 1'b0;
      lrclk = l;
      sdin  = d;
      repeat (3) @(negedge clk);
      bclk = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic start(input logic [2:0] f, input logic [1:0] w, input logic idle_lr);
      @(negedge clk);
      rst = 1'b1; fmt = f; wlen = w; bclk = 1'b0; lrclk = idle_lr;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      snaps.delete();
      expw.delete();
   endtask

   task automatic compare(input int nexp, input string tag_lo, input string tag_hi);
      chk(snaps.size() == nexp, "R10 frames per run", snaps.size(), nexp);
      for (int i = 0; i < snaps.size() && i < nexp; i++) begin
         for (int c = 0; c < NCH; c++) begin
            logic [SW-1:0] got = snaps[i][c*SW +: SW];
            chk(got == expw[i*NCH + c],
                $sformatf("%s frame %0d ch %0d", (c < 8) ? tag_lo : tag_hi, i, c),
                got, expw[i*NCH + c]);
         end
      end
   endtask

   // two-channel run: f = 0 I2S, 1 LJ, 2 RJ, 5..7 reserved
   task automatic stereo_run(input logic [2:0] f, input logic [1:0] wc, input int nfr,
                             input string tag);
      int W = nbits(wc);
      logic left_lvl = (f == 3'd0) ? 1'b0 : 1'b1;
      int unsigned wl[4];
      int unsigned wr[4];
      start(f, wc, ~left_lvl);
      // lead-in with data but no frame transition: nothing may be captured (R11)
      for (int b = 0; b < 40; b++) bit_out(~left_lvl, 4'($urandom));
      for (int fr = 0; fr < nfr; fr++) begin
         for (int p = 0; p < 4; p++) begin
            wl[p] = $urandom & ((32'd1 << W) - 1);
            wr[p] = $urandom & ((32'd1 << W) - 1);
         end
         if (f <= 3'd2) begin
            for (int c = 0; c < NCH; c++)
               expw.push_back((c < 8) ? sx((c % 2 == 0) ? wl[c/2] : wr[c/2], W) : '0);
         end
         for (int h = 0; h < 2; h++) begin
            for (int b = 0; b < 32; b++) begin
               logic [3:0] d = 4'($urandom);
               for (int p = 0; p < 4; p++) begin
                  int unsigned word = (h == 0) ? wl[p] : wr[p];
                  if (f == 3'd0) begin
                     if (b >= 1 && b <= W) d[p] = word[W-b];
                  end else if (f == 3'd2) begin
                     if (b >= 32 - W) d[p] = word[31-b];
                  end else begin
                     if (b < W) d[p] = word[W-1-b];
                  end
               end
               bit_out((h == 0) ? left_lvl : ~left_lvl, d);
            end
         end
      end
      for (int b = 0; b < 2; b++) bit_out(left_lvl, 4'($urandom));
      repeat (20) @(negedge clk);
      if (f <= 3'd2) begin
         compare(nfr, tag, "R11 upper words held");
      end else begin
         chk(snaps.size() == 0, "R2 reserved strobe count", snaps.size(), 0);
         chk(ch_data == '0, "R2 reserved words unchanged", ch_data[63:0], 0);
      end
   endtask

   // TDM run: f = 3 dual-wire, 4 single-wire
   task automatic tdm_run(input logic [2:0] f, input logic [1:0] wc, input int nfr,
                          input string tag);
      int W = nbits(wc);
      int slots = (f == 3'd3) ? 8 : 16;
      int unsigned w3[16];
      int unsigned w2[16];
      start(f, wc, 1'b0);
      for (int b = 0; b < 8; b++) bit_out(1'b0, 4'($urandom));
      for (int fr = 0; fr < nfr; fr++) begin
         for (int s = 0; s < 16; s++) begin
            w3[s] = $urandom & ((32'd1 << W) - 1);
            w2[s] = $urandom & ((32'd1 << W) - 1);
         end
         for (int c = 0; c < NCH; c++) begin
            if (f == 3'd3) expw.push_back((c < 8) ? sx(w3[c], W) : sx(w2[c-8], W));
            else           expw.push_back(sx(w2[c], W));
         end
         for (int s = 0; s < slots; s++) begin
            for (int b = 0; b < 32; b++) begin
               logic [3:0] d = 4'($urandom);
               if (b < W) begin
                  d[2] = w2[s][W-1-b];
                  if (f == 3'd3) d[3] = w3[s][W-1-b];
               end
               bit_out((s == 0 && b == 0), d);
            end
         end
      end
      for (int b = 0; b < 2; b++) bit_out(1'b0, 4'($urandom));
      repeat (20) @(negedge clk);
      compare(nfr, tag, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      start(3'd1, 2'd0, 1'b0);
      chk(ch_data == '0, "R12 words after reset", ch_data[63:0], 0);
      chk(frame_valid == 1'b0, "R12 strobe after reset", frame_valid, 0);

      stereo_run(3'd0, 2'd0, 3, "R1 R3 R6 I2S w16");
      stereo_run(3'd1, 2'd1, 3, "R4 R6 LJ w20");
      stereo_run(3'd2, 2'd2, 3, "R5 R6 RJ w24");
      stereo_run(3'd2, 2'd0, 2, "R5 R6 RJ w16");
      stereo_run(3'd0, 2'd3, 2, "R3 R6 I2S code3");
      stereo_run(3'd5, 2'd0, 2, "R2");
      tdm_run(3'd3, 2'd2, 2, "R7 R8 dual w24");
      tdm_run(3'd3, 2'd0, 1, "R7 R8 dual w16");
      tdm_run(3'd4, 2'd1, 2, "R7 R9 single w20");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R10 watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule